// File: doc/BRIEF.md
# Router Destination Port Selector

This block sits at the input of a packet-switching router that has up to 32 ports. Given the first byte of an arriving packet, its destination address, it decides where the packet goes. Addresses 1 to 31 name physical ports and addresses 32 to 255 are logical. Each address owns one setup word in an internal table. The setup word holds a flag per output port and a mode bit. With the mode bit set, the packet is sent to every enabled port whose link is up. With the mode bit clear, the block chooses one port from the enabled group, taking the first one that is free.

The table is loaded through a word-addressed configuration write bus. The word index equals the destination address, which is the byte offset divided by four. A separate strobe from the memory protection logic marks an entry as corrupted. A lookup starts on a one-cycle request strobe and ends with a one-cycle done strobe. At that point the result is either a port mask (plus the chosen port number in the one-port mode) or a discard flag. The result then stays on the outputs until the next request is accepted.

Top module: `dest_port_sel`

## Requirements
- R1: After reset, done, discard and the port mask are all low, and every table entry is empty, so that a lookup of any address is discarded.
- R2: A configuration write to word index A (1 to 255) stores bits NPORTS-1..1 of the data as the enable flags of ports NPORTS-1..1 for address A, and stores data bit 0 as the mode bit (1 = send to all, 0 = pick one). Writes to index 0 change nothing.
- R3: Data bits at or above NPORTS have no effect on port selection or on entry validity.
- R4: Each of the following gives done and discard one cycle after the accepted request, with a zero port mask and a port number of 0: a destination address of 0, an entry with no valid enable flag set, and an entry that was cleared by writing zero.
- R5: If the entry for the destination address has its error flag set (set by the error strobe with its address), the lookup is discarded.
- R6: A configuration write to an entry clears that entry's error flag. When a write and an error strobe hit the same entry in the same cycle, the write wins.
- R7: In pick-one mode, the result is the lowest-numbered enabled port whose link is up and which is ready. The mask has only that bit set, and the port number output gives its index.
- R8: In pick-one mode, when no enabled port is both up and ready, done stays low. The block re-evaluates every cycle and completes in the cycle after a port becomes available.
- R9: In send-to-all mode, the mask is the set of enabled ports whose link is up, and the port number output is 0. Done is raised only in the cycle after all of those ports are ready together.
- R10: A request that arrives while a lookup is pending is dropped and produces no result.
- R11: Done is a single-cycle pulse. The mask, port number and discard outputs hold their values after done until the next request is accepted, whatever happens on link and ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration word index (equal to the destination address) |
| cfg_wdata_i | input | 32 | Setup word: bit 0 is the mode, bit n enables port n |
| merr_set_i | input | 1 | Memory error strobe for one entry |
| merr_addr_i | input | 8 | Entry index that the error strobe refers to |
| req_i | input | 1 | Lookup request strobe |
| req_addr_i | input | 8 | Destination address byte |
| link_up_i | input | NPORTS-1 | Per-port link up, ports NPORTS-1..1 |
| ready_i | input | NPORTS-1 | Per-port ready to accept a packet, ports NPORTS-1..1 |
| done_o | output | 1 | One-cycle lookup completion pulse |
| discard_o | output | 1 | Packet must be dropped |
| port_mask_o | output | NPORTS-1 | Chosen output ports, ports NPORTS-1..1 |
| port_sel_o | output | clog2(NPORTS) | Chosen port index in pick-one mode, otherwise 0 |

## Verification
The bench stores an entry whose only set bits lie above the implemented ports. A design that forgot to mask those bits would treat the entry as valid and hang waiting for a port that does not exist, rather than discarding. In pick-one mode it takes away readiness or link on the lower enabled ports one at a time, and also holds every port busy for several cycles, to catch a wrong priority order or an early, empty completion. In send-to-all mode one member is kept busy, to catch a done that fires before all of them are ready. The bench also injects a memory error and then rewrites the entry, sends a second request while one is pending, and toggles link and ready after completion, to catch a stuck error flag, a phantom second result, or an output that tracks the inputs when it should hold.

// File: rtl/dps_pkg.sv
package dps_pkg;
    localparam int ADDR_W = 8;
    localparam int WORD_W = 32;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int MODE_BIT = 0;
    typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/dps_table.sv
module dps_table
    import dps_pkg::*;
#(
    parameter int NPORTS = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 we_i,
    input  addr_t                waddr_i,
    input  logic [WORD_W-1:0]    wdata_i,
    input  logic                 merr_set_i,
    input  addr_t                merr_addr_i,
    input  addr_t                raddr_i,
    output logic [NPORTS-1:1]    rd_en_o,
    output logic                 rd_pd_o,
    output logic                 rd_err_o
);
    typedef struct packed {
        logic [NPORTS-1:1] en;
        logic              pd;
        logic              err;
    } entry_t;

    entry_t tab_q [DEPTH];
    entry_t tab_d [DEPTH];

    // Only the implemented enable bits are kept; the rest are dropped here.
    generate
        if (NPORTS < WORD_W) begin : g_hi_sink
            logic unused_hi;
            assign unused_hi = ^wdata_i[WORD_W-1:NPORTS];
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < DEPTH; i++) tab_d[i] = tab_q[i];
        if (merr_set_i) tab_d[merr_addr_i].err = 1'b1;
        if (we_i && waddr_i != '0) begin
            tab_d[waddr_i].en  = wdata_i[NPORTS-1:1];
            tab_d[waddr_i].pd  = wdata_i[MODE_BIT];
            tab_d[waddr_i].err = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int i = 0; i < DEPTH; i++) tab_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) tab_q[i] <= tab_d[i];
        end
    end

    assign rd_en_o  = tab_q[raddr_i].en;
    assign rd_pd_o  = tab_q[raddr_i].pd;
    assign rd_err_o = tab_q[raddr_i].err;

    // R6: a write leaves its entry free of the error flag
    a_r6_write_clears_err: assert property (@(posedge clk_i) disable iff (rst_i)
        (we_i && waddr_i != '0) |=> !tab_q[$past(waddr_i)].err);

    // R2: writes to index 0 never populate entry 0
    a_r2_reserved_empty: assert property (@(posedge clk_i) disable iff (rst_i)
        tab_q[0].en == '0);
endmodule

// File: rtl/dps_lowest.sv
module dps_lowest #(
    parameter int NPORTS = 8,
    parameter int SEL_W  = 3
) (
    input  logic [NPORTS-1:1] vec_i,
    output logic [NPORTS-1:1] onehot_o,
    output logic [SEL_W-1:0]  idx_o,
    output logic              any_o
);
    always_comb begin
        onehot_o = '0;
        idx_o    = '0;
        for (int i = NPORTS - 1; i >= 1; i--) begin
            if (vec_i[i]) begin
                onehot_o    = '0;
                onehot_o[i] = 1'b1;
                idx_o       = SEL_W'(i);
            end
        end
        any_o = |vec_i;
    end
endmodule

// File: rtl/dest_port_sel.sv
module dest_port_sel
    import dps_pkg::*;
#(
    parameter int NPORTS = 8,
    localparam int SEL_W = $clog2(NPORTS)
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 cfg_we_i,
    input  logic [ADDR_W-1:0]    cfg_addr_i,
    input  logic [WORD_W-1:0]    cfg_wdata_i,
    input  logic                 merr_set_i,
    input  logic [ADDR_W-1:0]    merr_addr_i,
    input  logic                 req_i,
    input  logic [ADDR_W-1:0]    req_addr_i,
    input  logic [NPORTS-1:1]    link_up_i,
    input  logic [NPORTS-1:1]    ready_i,
    output logic                 done_o,
    output logic                 discard_o,
    output logic [NPORTS-1:1]    port_mask_o,
    output logic [SEL_W-1:0]     port_sel_o
);
    typedef struct packed {
        logic              busy;
        addr_t             addr;
        logic [NPORTS-1:1] mask;
        logic [SEL_W-1:0]  sel;
        logic              disc;
        logic              done;
    } state_t;

    state_t st_d, st_q;

    logic [NPORTS-1:1] ent_en;
    logic              ent_pd;
    logic              ent_err;
    logic [NPORTS-1:1] free_vec;
    logic [NPORTS-1:1] pick_oh;
    logic [SEL_W-1:0]  pick_idx;
    logic              pick_any;
    logic [NPORTS-1:1] need_vec;
    logic              entry_ok;

    dps_table #(.NPORTS(NPORTS)) u_table (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .we_i        (cfg_we_i),
        .waddr_i     (cfg_addr_i),
        .wdata_i     (cfg_wdata_i),
        .merr_set_i  (merr_set_i),
        .merr_addr_i (merr_addr_i),
        .raddr_i     (st_q.addr),
        .rd_en_o     (ent_en),
        .rd_pd_o     (ent_pd),
        .rd_err_o    (ent_err)
    );

    assign free_vec = ent_en & link_up_i & ready_i;
    assign need_vec = ent_en & link_up_i;

    dps_lowest #(.NPORTS(NPORTS), .SEL_W(SEL_W)) u_lowest (
        .vec_i    (free_vec),
        .onehot_o (pick_oh),
        .idx_o    (pick_idx),
        .any_o    (pick_any)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        entry_ok  = (|ent_en) && !ent_err && (st_q.addr != '0);
        if (!st_q.busy) begin
            if (req_i) begin
                st_d.busy = 1'b1;
                st_d.addr = req_addr_i;
                st_d.mask = '0;
                st_d.sel  = '0;
                st_d.disc = 1'b0;
            end
        end else if (!entry_ok) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
            st_d.disc = 1'b1;
        end else if (ent_pd) begin
            if ((|need_vec) && ((need_vec & ~ready_i) == '0)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.mask = need_vec;
            end
        end else if (pick_any) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
            st_d.mask = pick_oh;
            st_d.sel  = pick_idx;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign done_o      = st_q.done;
    assign discard_o   = st_q.disc;
    assign port_mask_o = st_q.mask;
    assign port_sel_o  = st_q.sel;

    a_r4_discard_no_mask: assert property (@(posedge clk_i) disable iff (rst_i)
        discard_o |-> (port_mask_o == '0));

    a_r9_mask_ready: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> ((port_mask_o & ~$past(ready_i)) == '0));

    a_r9_mask_link: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> ((port_mask_o & ~$past(link_up_i)) == '0));

    a_r11_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o);

    a_r11_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (!st_q.busy && !req_i) |=> ($stable(port_mask_o) && $stable(discard_o) && !done_o));

    a_r10_one_result: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> $past(st_q.busy));
endmodule

// File: tb/dest_port_sel_test.sv
module dest_port_sel_test;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        merr_set = 1'b0;
    logic [7:0]  merr_addr = '0;
    logic        req = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [7:1]  link = '1;
    logic [7:1]  rdy = '1;
    logic        done_o, discard_o;
    logic [7:1]  mask_o;
    logic [2:0]  sel_o;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [7:1] mask;
        logic [2:0] sel;
        logic       disc;
    } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dest_port_sel #(.NPORTS(NP)) uut (
        .clk_i(clk), .rst_i(rst),
        .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
        .merr_set_i(merr_set), .merr_addr_i(merr_addr),
        .req_i(req), .req_addr_i(req_addr),
        .link_up_i(link), .ready_i(rdy),
        .done_o(done_o), .discard_o(discard_o),
        .port_mask_o(mask_o), .port_sel_o(sel_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:1] pm(input logic [7:0] b);
        return b[7:1];
    endfunction

    // Monitor: pops expected results as done pulses appear
    always @(negedge clk) begin
        if (!rst && done_o) begin
            if (exp_q.size() == 0) begin
                chk("R10 unexpected done", 32'(done_o), 32'd0);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({t, " mask"}, 32'(mask_o), 32'(e.mask));
                chk({t, " sel"},  32'(sel_o),  32'(e.sel));
                chk({t, " disc"}, 32'(discard_o), 32'(e.disc));
            end
        end
    end

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic issue(input logic [7:0] a, input logic [7:0] m, input int s,
                         input bit d, input string tag);
        exp_t e;
        e.mask = pm(m); e.sel = 3'(s); e.disc = d;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        req = 1'b1; req_addr = a;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (exp_q.size() != 0 && n < 50) begin
            @(negedge clk);
            n++;
        end
        if (exp_q.size() != 0) begin
            chk({tag, " no result"}, 32'(exp_q.size()), 32'd0);
            exp_q.delete(); tag_q.delete();
        end
    endtask

    task automatic lookup(input logic [7:0] a, input logic [7:0] m, input int s,
                          input bit d, input string tag);
        issue(a, m, s, d, tag);
        wait_done(tag);
    endtask

    task automatic no_done(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(tag, 32'(done_o), 32'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 done", 32'(done_o), 32'd0);
        chk("R1 discard", 32'(discard_o), 32'd0);
        chk("R1 mask", 32'(mask_o), 32'd0);
        lookup(8'd77, 8'h00, 0, 1'b1, "R1 empty table");

        // R2 / R7 pick-one: ports 2,4,6
        cfg_write(8'd5, 32'h0000_0054);
        lookup(8'd5, 8'h04, 2, 1'b0, "R7 lowest port 2");
        rdy = 7'b1111111; rdy[2] = 1'b0;
        lookup(8'd5, 8'h10, 4, 1'b0, "R7 skip busy port");
        link[4] = 1'b0;
        lookup(8'd5, 8'h40, 6, 1'b0, "R7 skip down link");
        link = '1;

        // R8 waits for a free port
        rdy = '0;
        issue(8'd5, 8'h40, 6, 1'b0, "R8 late port 6");
        no_done(3, "R8 no early done");
        rdy[6] = 1'b1;
        wait_done("R8");
        rdy = '1;

        // R9 send-to-all: ports 1,3,7 with port 3 down
        cfg_write(8'd200, 32'h0000_008B);
        link[3] = 1'b0;
        lookup(8'd200, 8'h82, 0, 1'b0, "R9 up members");
        rdy[7] = 1'b0;
        issue(8'd200, 8'h82, 0, 1'b0, "R9 wait all ready");
        no_done(3, "R9 no partial done");
        rdy[7] = 1'b1;
        wait_done("R9");
        link = '1;

        // R4 discards
        lookup(8'd0, 8'h00, 0, 1'b1, "R4 address zero");
        cfg_write(8'd0, 32'h0000_00FE);
        lookup(8'd0, 8'h00, 0, 1'b1, "R4 reserved write");
        cfg_write(8'd100, 32'h0000_0004);
        lookup(8'd100, 8'h04, 2, 1'b0, "R2 logical entry");
        cfg_write(8'd100, 32'h0000_0000);
        lookup(8'd100, 8'h00, 0, 1'b1, "R4 cleared entry");

        // R3 bits above the implemented ports
        cfg_write(8'd33, 32'h8000_0200);
        lookup(8'd33, 8'h00, 0, 1'b1, "R3 only high bits");
        cfg_write(8'd34, 32'h8000_0008);
        lookup(8'd34, 8'h08, 3, 1'b0, "R3 high bit ignored");

        // R5 / R6 memory error
        @(negedge clk);
        merr_set = 1'b1; merr_addr = 8'd5;
        @(negedge clk);
        merr_set = 1'b0;
        lookup(8'd5, 8'h00, 0, 1'b1, "R5 error discard");
        cfg_write(8'd5, 32'h0000_0054);
        lookup(8'd5, 8'h04, 2, 1'b0, "R6 rewrite clears");
        @(negedge clk);
        merr_set = 1'b1; merr_addr = 8'd5;
        cfg_we = 1'b1; cfg_addr = 8'd5; cfg_wdata = 32'h0000_0010;
        @(negedge clk);
        merr_set = 1'b0; cfg_we = 1'b0;
        lookup(8'd5, 8'h10, 4, 1'b0, "R6 write wins");

        // R10 request while pending is dropped
        exp_q.push_back('{mask: pm(8'h10), sel: 3'd4, disc: 1'b0});
        tag_q.push_back("R10 first result");
        @(negedge clk);
        req = 1'b1; req_addr = 8'd5;
        @(negedge clk);
        req_addr = 8'd0;
        @(negedge clk);
        req = 1'b0;
        wait_done("R10");
        no_done(3, "R10 dropped request");

        // R11 outputs hold after done
        rdy = '0; link[4] = 1'b0;
        no_done(3, "R11 no new done");
        chk("R11 mask held", 32'(mask_o), 32'(pm(8'h10)));
        chk("R11 sel held", 32'(sel_o), 32'd4);
        chk("R11 discard held", 32'(discard_o), 32'd0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule